// File: doc/BRIEF.md
# Registered Octal Bus Transceiver

This block connects two 8-bit buses, called A and B. Each direction of transfer has its own holding register with its own clock. The A-to-B register samples the A bus. The B-to-A register samples the B bus. One active-low output enable and one direction input decide which port, if any, is driven. For each direction, a select line decides whether the driven port carries the live value from the opposite bus or the contents of that direction's register.

Each bus is split into an input vector, an output vector and a per-bit output-enable vector, so the block stays synthesizable with no tri-state pins. With output enable inactive, neither port drives, but both registers keep sampling on their own clocks. This supports four modes of use:

- passing data through in real time;
- storing data while both ports are isolated;
- driving out previously stored data;
- storing data while a transfer is in progress.

Top module: `regxcvr_top`

## Requirements
- R1: The A-to-B register loads `a_in` on each rising edge of `clk_ab`. The B-to-A register loads `b_in` on each rising edge of `clk_ba`. An edge on one clock never changes the other register.
- R2: While `oe_n` is 1 (isolation), `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` are zero.
- R3: While isolated, either register or both still load on their own clock edges. The stored values appear once a port is enabled with its stored select set.
- R4: While `oe_n` is 0, `dir` = 1 drives B: `b_oe` is all ones and `a_oe` is all zeros. `dir` = 0 drives A: `a_oe` is all ones and `b_oe` is all zeros. The two enable vectors are never both non-zero.
- R5: When B is driven, `sel_ab` = 0 puts live `a_in` on `b_out` with no clock needed. `sel_ab` = 1 puts the A-to-B register on `b_out`.
- R6: When A is driven, `sel_ba` = 0 puts live `b_in` on `a_out`. `sel_ba` = 1 puts the B-to-A register on `a_out`.
- R7: `oe_n`, `dir`, `sel_ab` and `sel_ba` never alter register contents. With no clock edge, any changes on these inputs leave the stored values unchanged.
- R8: `rst` is synchronous and active high. A rising edge of a register's own clock while `rst` is 1 clears that register to zero, and leaves the other register untouched.
- R9: A port that is driving stored data shows the new register value right after the capturing edge, with no extra pipeline stage.
- R10: A port that is not driven outputs zero on its output vector, whatever the live data on the other bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Load clock of the A-to-B register |
| clk_ba | input | 1 | Load clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, applied on each register's own clock |
| oe_n | input | 1 | Active-low output enable (1 = isolation) |
| dir | input | 1 | 1 = drive B from A side, 0 = drive A from B side |
| sel_ab | input | 1 | B-port source: 0 live A data, 1 A-to-B register |
| sel_ba | input | 1 | A-port source: 0 live B data, 1 B-to-A register |
| a_in | input | WIDTH | Value seen on bus A |
| b_in | input | WIDTH | Value seen on bus B |
| a_out | output | WIDTH | Value driven onto bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_out | output | WIDTH | Value driven onto bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The bench targets the following corner cases and the failure each one would reveal:

- **Capture on the receiving port.** During a live A-to-B transfer, the bench clocks data on the receiving B side into the B-to-A register. A design that loads registers only from the driving side would later replay stale B data.
- **Isolation.** The bench captures while isolated, then toggles the controls with no clock edge. A design that gates loads with the output enable, or that lets a select or direction change disturb storage, shows the wrong stored byte.
- **Same-edge visibility.** The bench clocks a new byte while stored data is being driven. A design with an extra output register would show the old byte for one cycle.
- **Per-clock reset.** The bench applies reset with only one clock pulsed. A design that clears both registers from either clock loses the other register's byte.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

    // Transfer direction encoding as applied on the dir pin
    typedef enum logic {
        DIR_TO_A = 1'b0,
        DIR_TO_B = 1'b1
    } xfer_dir_e;

    // Which port the control decode enables
    typedef struct packed {
        logic to_a;
        logic to_b;
    } drive_t;

    // Index of each transfer path inside the generate loop
    localparam int PATH_AB = 0;
    localparam int PATH_BA = 1;
    localparam int NUM_PATHS = 2;

    function automatic drive_t decode_drive(input logic oe_n, input xfer_dir_e dir);
        drive_t d;
        d.to_a = !oe_n && (dir == DIR_TO_A);
        d.to_b = !oe_n && (dir == DIR_TO_B);
        return d;
    endfunction

endpackage

// File: rtl/regxcvr_store.sv
module regxcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d)))
        else $error("store did not load on own edge"); // R1

    AST_SYNC_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0))
        else $error("store not cleared by reset"); // R8

endmodule

// File: rtl/regxcvr_drive_ctrl.sv
module regxcvr_drive_ctrl
    import regxcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drive
);

    always_comb begin
        drive = decode_drive(oe_n, xfer_dir_e'(dir));
    end

endmodule

// File: rtl/regxcvr_path_mux.sv
module regxcvr_path_mux #(
    parameter int WIDTH = 8
) (
    input  logic             enable,
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] y_oe
);

    logic [WIDTH-1:0] picked;

    always_comb begin
        picked = use_stored ? stored : live;
        y      = enable ? picked : '0;
        y_oe   = {WIDTH{enable}};
    end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top
    import regxcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    drive_t drive;

    logic [NUM_PATHS-1:0]            path_clk;
    logic [NUM_PATHS-1:0]            path_en;
    logic [NUM_PATHS-1:0]            path_sel;
    logic [NUM_PATHS-1:0][WIDTH-1:0] path_src;
    logic [NUM_PATHS-1:0][WIDTH-1:0] path_q;
    logic [NUM_PATHS-1:0][WIDTH-1:0] path_y;
    logic [NUM_PATHS-1:0][WIDTH-1:0] path_oe;

    regxcvr_drive_ctrl u_ctrl (
        .oe_n  (oe_n),
        .dir   (dir),
        .drive (drive)
    );

    // Path wiring: A-to-B samples A and drives B; B-to-A the reverse
    always_comb begin
        path_clk[PATH_AB] = clk_ab;
        path_en [PATH_AB] = drive.to_b;
        path_sel[PATH_AB] = sel_ab;
        path_src[PATH_AB] = a_in;
        path_clk[PATH_BA] = clk_ba;
        path_en [PATH_BA] = drive.to_a;
        path_sel[PATH_BA] = sel_ba;
        path_src[PATH_BA] = b_in;
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        regxcvr_store #(.WIDTH(WIDTH)) u_store (
            .clk (path_clk[p]),
            .rst (rst),
            .d   (path_src[p]),
            .q   (path_q[p])
        );
        regxcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
            .enable     (path_en[p]),
            .use_stored (path_sel[p]),
            .live       (path_src[p]),
            .stored     (path_q[p]),
            .y          (path_y[p]),
            .y_oe       (path_oe[p])
        );
    end

    always_comb begin
        b_out = path_y [PATH_AB];
        b_oe  = path_oe[PATH_AB];
        a_out = path_y [PATH_BA];
        a_oe  = path_oe[PATH_BA];
    end

    always_comb begin
        AST_ISOLATE: assert (!oe_n || (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0))
            else $error("port driven during isolation"); // R2
        AST_ONE_PORT: assert (!((|a_oe) && (|b_oe)))
            else $error("both ports enabled"); // R4
        AST_LIVE_B: assert (!((&b_oe) && !sel_ab) || (b_out == a_in))
            else $error("live A data not on B"); // R5
        AST_LIVE_A: assert (!((&a_oe) && !sel_ba) || (a_out == b_in))
            else $error("live B data not on A"); // R6
        AST_IDLE_ZERO: assert (((|a_oe) || a_out == '0) && ((|b_oe) || b_out == '0))
            else $error("undriven port not zero"); // R10
    end

endmodule

// File: tb/sim_regxcvr_top.sv
module sim_regxcvr_top;

    localparam int W = 8;

    typedef struct packed {
        logic         oe_n;
        logic         dir;
        logic         sel_ab;
        logic         sel_ba;
        logic         ck_ab;
        logic         ck_ba;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } vec_t;

    // oe_n dir sab sba ckab ckba a b
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h00}, // live A->B
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3}, // live B->A
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22}, // store both, isolated
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'h00}, // stored A->B
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h77}, // stored B->A
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h00}, // store while live transfer
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00}, // replay stored
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE7, 8'h00}, // store while stored transfer
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81}, // isolated, B only
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}, // replay B store
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h4D}, // capture receiving side
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}  // replay it
    };

    logic clk = 1'b0;
    logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    int cyc = 0;
    logic done = 1'b0;

    regxcvr_top #(.WIDTH(W)) u0 (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .b_in (b_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive controls/data, pulse requested clocks, sample 1 ns after the edge
    task automatic step(input vec_t v);
        oe_n = v.oe_n; dir = v.dir; sel_ab = v.sel_ab; sel_ba = v.sel_ba;
        a_in = v.a; b_in = v.b;
        #2;
        if (v.ck_ab) begin clk_ab = 1'b1; m_ab = rst ? '0 : v.a; end
        if (v.ck_ba) begin clk_ba = 1'b1; m_ba = rst ? '0 : v.b; end
        #1;
    endtask

    task automatic release_clks();
        #1; clk_ab = 1'b0; clk_ba = 1'b0; #2;
    endtask

    function automatic logic [4*W-1:0] model(input vec_t v);
        logic to_a, to_b;
        logic [W-1:0] ea, eb;
        to_b = !v.oe_n && v.dir;
        to_a = !v.oe_n && !v.dir;
        eb = to_b ? (v.sel_ab ? m_ab : v.a) : '0;
        ea = to_a ? (v.sel_ba ? m_ba : v.b) : '0;
        return {ea, {W{to_a}}, eb, {W{to_b}}};
    endfunction

    initial begin
        vec_t v;
        // R8: reset clears both registers on their own edges
        step('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55});
        release_clks();
        rst = 1'b0;
        // R2: reset state, isolated
        step('{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF});
        check("R2 a_oe reset", a_oe, '0);
        check("R2 b_out reset", b_out, '0);
        release_clks();
        step('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF});
        check("R8 A-to-B cleared", b_out, '0);
        release_clks();
        step('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF});
        check("R8 B-to-A cleared", a_out, '0);
        release_clks();

        // Table walk: R3 R4 R5 R6 R9 R10 against the model
        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
            n_chk++;
            if ({a_out, a_oe, b_out, b_oe} !== model(VECS[i])) begin
                n_bad++;
                $display("FAIL R3/R4/R5/R6/R9/R10 row %0d: actual %h expected %h",
                         i, {a_out, a_oe, b_out, b_oe}, model(VECS[i]));
            end
            release_clks();
        end

        // R7: control churn with no clock edges leaves stores intact
        for (int k = 0; k < 16; k++) begin
            v = '{k[0], k[1], k[2], k[3], 1'b0, 1'b0, 8'h00, 8'h00};
            step(v);
            release_clks();
        end
        step('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00});
        check("R7 A-to-B kept", b_out, 8'hE7);
        release_clks();
        step('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
        check("R7 B-to-A kept", a_out, 8'h4D);
        release_clks();

        // R1: clk_ba edge must not touch A-to-B register
        step('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0F, 8'hB2});
        check("R1 cross clock isolation", b_out, 8'hE7);
        release_clks();
        step('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
        check("R1 B-to-A loaded", a_out, 8'hB2);
        release_clks();

        // R9: new value visible right after edge while stored data is driven
        step('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h6E});
        check("R9 same-edge update", a_out, 8'h6E);
        release_clks();

        // R10: A undriven while B takes live data
        step('{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44, 8'hFF});
        check("R10 idle A zero", a_out, '0);
        check("R4 a_oe low when B driven", a_oe, '0);
        release_clks();

        // R8: reset with only clk_ab clears only A-to-B
        rst = 1'b1;
        step('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h99, 8'h00});
        release_clks();
        rst = 1'b0;
        step('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00});
        check("R8 A-to-B cleared alone", b_out, '0);
        release_clks();
        step('{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00});
        check("R8 B-to-A untouched", a_out, 8'h6E);
        release_clks();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule